// File: doc/BRIEF.md
# Duplicated Event Counter with Fatal Escalation

This block counts command events with two independent copies of the same counter. One copy keeps the true value. The other keeps the bitwise complement. Every operation (load, increment, clear) is applied to both copies through separate next-value logic. A comparator decodes both copies and checks them on every cycle. If they ever disagree, a sticky fault bit is set, the fatal interrupt rises, and the control state machine is driven into a locked state. Only reset leaves that state.

The control state machine runs one counting job at a time. A start pulse loads a base value and captures a limit. Each step pulse then advances the count. When the count reaches the limit, a one-cycle done indication is given and the counter clears. The state register uses a sparse encoding, and any pattern outside the four legal codes is also a fatal fault with its own bit. Three test inputs exist to exercise the fatal path: one overwrites the complemented copy, one overwrites the state register, and one sets a chosen fault bit directly.

Top module: `redun_cnt_guard`

## Requirements
- R1: After reset, cnt_o is 0, fault_o is 0, and intr_fatal_o, locked_o, busy_o and done_o are all low.
- R2: In the idle state, a start_i pulse loads cnt_o with base_i and captures lim_i. busy_o is high from the next cycle. While busy, each cycle with step_i high adds 1 to cnt_o, and a cycle with step_i low leaves cnt_o unchanged.
- R3: While busy, if cnt_o equals the captured limit, done_o is high for exactly one cycle with cnt_o still showing the limit. In the cycle after that the block is idle and cnt_o is 0. A job whose base equals its limit reaches done one cycle after busy_o rises.
- R4: The count wraps modulo 2^CNT_W. For example, base 0xFE with limit 0x01 finishes after three steps.
- R5: When the decoded copies differ, fault_o bit 0 is set in the following cycle.
- R6: The second copy is stored complemented. Overwriting it with the complement of the true count leaves fault_o at 0.
- R7: fault_o bits stay set until reset. intr_fatal_o is high exactly when any fault_o bit is set.
- R8: One cycle after any fault_o bit is set, locked_o goes high and stays high. While locked, start_i and step_i are ignored and cnt_o does not change.
- R9: The legal state codes are 6'b010110 (idle), 6'b101011 (busy), 6'b110101 (done) and 6'b001100 (locked). Any other code in the state register sets fault_o bit 1 and moves the machine to locked on the next edge.
- R10: A pulse on flt_set_i sets the fault_o bit selected by flt_sel_i in the following cycle, and this escalates exactly like a real fault.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start_i | input | 1 | Begin a counting job (idle only) |
| step_i | input | 1 | Count one event while busy |
| base_i | input | CNT_W | Start value loaded by start_i |
| lim_i | input | CNT_W | Terminal value captured by start_i |
| inj_cnt_i | input | 1 | Test: overwrite the complemented copy |
| inj_cnt_val_i | input | CNT_W | Raw value written into the complemented copy |
| inj_st_i | input | 1 | Test: overwrite the state register |
| inj_st_val_i | input | 6 | Raw state code written |
| flt_set_i | input | 1 | Test: set one fault bit |
| flt_sel_i | input | 1 | Index of the fault bit to set |
| cnt_o | output | CNT_W | Current count (true copy) |
| busy_o | output | 1 | Job in progress |
| done_o | output | 1 | One-cycle job completion |
| locked_o | output | 1 | Terminal state reached |
| fault_o | output | 2 | Sticky fault bits: 0 copy mismatch, 1 illegal state |
| intr_fatal_o | output | 1 | Fatal interrupt |

## Verification
The assertions rely on these input assumptions. The three injection inputs are held low during normal counting, and no state overwrite happens in the same cycle as an escalation. The counter-hold property also assumes that no load, increment or clear is in flight. The stimulus injects exactly one fault per reset interval, always from idle or busy, and resets the block before the next fault scenario. This keeps every escalation property on its intended path.

// File: rtl/rcg_pkg.sv
package rcg_pkg;
  localparam int unsigned ST_W  = 6;
  localparam int unsigned ERR_N = 2;
  localparam int unsigned ERR_IW = (ERR_N > 1) ? $clog2(ERR_N) : 1;
  localparam int unsigned ERR_CNT = 0;
  localparam int unsigned ERR_FSM = 1;

  // pairwise Hamming distance of at least 3
  typedef enum logic [ST_W-1:0] {
    ST_IDLE = 6'b010110,
    ST_RUN  = 6'b101011,
    ST_DONE = 6'b110101,
    ST_TERM = 6'b001100
  } rcg_state_e;

  typedef enum logic [1:0] {
    OP_NONE = 2'd0,
    OP_CLR  = 2'd1,
    OP_LD   = 2'd2,
    OP_INC  = 2'd3
  } rcg_op_e;
endpackage

// File: rtl/rcg_cnt_copy.sv
module rcg_cnt_copy
  import rcg_pkg::*;
#(
  parameter int unsigned W   = 8,
  parameter bit          INV = 1'b0
) (
  input  logic         clk,
  input  logic         rst_n,
  input  rcg_op_e      op_i,
  input  logic [W-1:0] ld_val_i,
  input  logic         inj_i,
  input  logic [W-1:0] inj_val_i,
  output logic [W-1:0] val_o
);
  localparam logic [W-1:0] RST_Q = {W{INV}};

  logic [W-1:0] q;
  logic [W-1:0] q_d;
  logic [W-1:0] plain;
  logic [W-1:0] plain_nx;
  logic [W-1:0] enc_nx;
  logic         en;

  if (INV) begin : g_inv
    assign plain  = ~q;
    assign enc_nx = ~plain_nx;
  end else begin : g_true
    assign plain  = q;
    assign enc_nx = plain_nx;
  end

  always_comb begin
    case (op_i)
      OP_CLR:  plain_nx = '0;
      OP_LD:   plain_nx = ld_val_i;
      OP_INC:  plain_nx = plain + W'(1);
      default: plain_nx = plain;
    endcase
  end

  assign en  = inj_i | (op_i != OP_NONE);
  assign q_d = inj_i ? inj_val_i : enc_nx;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      q <= RST_Q;
    end else if (en) begin
      q <= q_d;
    end
  end

  assign val_o = plain;

  AST_CNT_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (!inj_i && op_i == OP_NONE) |=> $stable(q))
    else $error("copy changed with no operation"); // R2
endmodule

// File: rtl/rcg_err_reg.sv
module rcg_err_reg
  import rcg_pkg::*;
#(
  parameter int unsigned N  = ERR_N,
  parameter int unsigned IW = ERR_IW
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic [N-1:0]  src_i,
  input  logic          tst_set_i,
  input  logic [IW-1:0] tst_sel_i,
  output logic [N-1:0]  err_o,
  output logic          any_o
);
  logic [N-1:0] err_q;
  logic [N-1:0] set;

  for (genvar g = 0; g < N; g++) begin : g_bit
    assign set[g] = src_i[g] | (tst_set_i && (tst_sel_i == IW'(g)));

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        err_q[g] <= 1'b0;
      end else if (set[g]) begin
        err_q[g] <= 1'b1;
      end
    end

    AST_ERR_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
      err_q[g] |=> err_q[g])
      else $error("fault bit cleared without reset"); // R7
  end

  assign err_o = err_q;
  assign any_o = |err_q;
endmodule

// File: rtl/rcg_main_fsm.sv
module rcg_main_fsm
  import rcg_pkg::*;
#(
  parameter int unsigned W = 8
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            start_i,
  input  logic            step_i,
  input  logic [W-1:0]    cnt_i,
  input  logic [W-1:0]    lim_i,
  input  logic            esc_i,
  input  logic            inj_i,
  input  logic [ST_W-1:0] inj_val_i,
  output rcg_op_e         op_o,
  output logic            illegal_o,
  output logic            busy_o,
  output logic            done_o,
  output logic            locked_o
);
  rcg_state_e   st_q;
  rcg_state_e   st_d;
  logic [W-1:0] lim_q;
  logic         lim_en;
  rcg_op_e      op;

  always_comb begin
    st_d   = st_q;
    op     = OP_NONE;
    lim_en = 1'b0;
    case (st_q)
      ST_IDLE: begin
        if (start_i) begin
          op     = OP_LD;
          lim_en = 1'b1;
          st_d   = ST_RUN;
        end
      end
      ST_RUN: begin
        if (cnt_i == lim_q) begin
          st_d = ST_DONE;
        end else if (step_i) begin
          op = OP_INC;
        end
      end
      ST_DONE: begin
        op   = OP_CLR;
        st_d = ST_IDLE;
      end
      ST_TERM: st_d = ST_TERM;
      default: st_d = ST_TERM;
    endcase
    if (esc_i) begin
      st_d   = ST_TERM;
      op     = OP_NONE;
      lim_en = 1'b0;
    end
    if (inj_i) begin
      st_d = rcg_state_e'(inj_val_i);
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q <= ST_IDLE;
    end else begin
      st_q <= st_d;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      lim_q <= '0;
    end else if (lim_en) begin
      lim_q <= lim_i;
    end
  end

  always_comb begin
    case (st_q)
      ST_IDLE, ST_RUN, ST_DONE, ST_TERM: illegal_o = 1'b0;
      default:                           illegal_o = 1'b1;
    endcase
  end

  assign op_o     = op;
  assign busy_o   = (st_q == ST_RUN);
  assign done_o   = (st_q == ST_DONE);
  assign locked_o = (st_q == ST_TERM);

  AST_ESC_LOCK: assert property (@(posedge clk) disable iff (!rst_n)
    (esc_i && !inj_i) |=> (st_q == ST_TERM))
    else $error("escalation did not lock"); // R8
  AST_LOCK_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (st_q == ST_TERM && !inj_i) |=> (st_q == ST_TERM))
    else $error("left terminal state"); // R8
  AST_ILLEGAL_LOCK: assert property (@(posedge clk) disable iff (!rst_n)
    (illegal_o && !inj_i) |=> (st_q == ST_TERM))
    else $error("illegal code not trapped"); // R9
endmodule

// File: rtl/redun_cnt_guard.sv
module redun_cnt_guard
  import rcg_pkg::*;
#(
  parameter int unsigned CNT_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start_i,
  input  logic              step_i,
  input  logic [CNT_W-1:0]  base_i,
  input  logic [CNT_W-1:0]  lim_i,
  input  logic              inj_cnt_i,
  input  logic [CNT_W-1:0]  inj_cnt_val_i,
  input  logic              inj_st_i,
  input  logic [ST_W-1:0]   inj_st_val_i,
  input  logic              flt_set_i,
  input  logic [ERR_IW-1:0] flt_sel_i,
  output logic [CNT_W-1:0]  cnt_o,
  output logic              busy_o,
  output logic              done_o,
  output logic              locked_o,
  output logic [ERR_N-1:0]  fault_o,
  output logic              intr_fatal_o
);
  localparam int unsigned N_COPY = 2;

  rcg_op_e          op;
  logic [CNT_W-1:0] val [N_COPY];
  logic             mismatch;
  logic             illegal;
  logic             esc;
  logic [ERR_N-1:0] src;

  for (genvar g = 0; g < N_COPY; g++) begin : g_copy
    rcg_cnt_copy #(
      .W   (CNT_W),
      .INV (g == 1)
    ) u_copy (
      .clk       (clk),
      .rst_n     (rst_n),
      .op_i      (op),
      .ld_val_i  (base_i),
      .inj_i     ((g == 1) ? inj_cnt_i : 1'b0),
      .inj_val_i (inj_cnt_val_i),
      .val_o     (val[g])
    );
  end

  assign mismatch = (val[0] != val[1]);

  always_comb begin
    src          = '0;
    src[ERR_CNT] = mismatch;
    src[ERR_FSM] = illegal;
  end

  rcg_err_reg #(
    .N  (ERR_N),
    .IW (ERR_IW)
  ) u_err (
    .clk       (clk),
    .rst_n     (rst_n),
    .src_i     (src),
    .tst_set_i (flt_set_i),
    .tst_sel_i (flt_sel_i),
    .err_o     (fault_o),
    .any_o     (esc)
  );

  rcg_main_fsm #(
    .W (CNT_W)
  ) u_fsm (
    .clk       (clk),
    .rst_n     (rst_n),
    .start_i   (start_i),
    .step_i    (step_i),
    .cnt_i     (val[0]),
    .lim_i     (lim_i),
    .esc_i     (esc),
    .inj_i     (inj_st_i),
    .inj_val_i (inj_st_val_i),
    .op_o      (op),
    .illegal_o (illegal),
    .busy_o    (busy_o),
    .done_o    (done_o),
    .locked_o  (locked_o)
  );

  assign cnt_o        = val[0];
  assign intr_fatal_o = esc;

  AST_MISMATCH_FLAG: assert property (@(posedge clk) disable iff (!rst_n)
    mismatch |=> fault_o[ERR_CNT])
    else $error("mismatch not recorded"); // R5
  AST_DONE_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
    done_o |=> !done_o)
    else $error("done longer than one cycle"); // R3
endmodule

// File: tb/tb_redun_cnt_guard.sv
`timescale 1ns/1ps
module tb_redun_cnt_guard;
  localparam int W = 8;

  logic         clk = 1'b0;
  logic         rst_n;
  logic         start_i, step_i;
  logic [W-1:0] base_i, lim_i;
  logic         inj_cnt_i;
  logic [W-1:0] inj_cnt_val_i;
  logic         inj_st_i;
  logic [5:0]   inj_st_val_i;
  logic         flt_set_i;
  logic [0:0]   flt_sel_i;
  logic [W-1:0] cnt_o;
  logic         busy_o, done_o, locked_o, intr_fatal_o;
  logic [1:0]   fault_o;

  int n_chk = 0;
  int n_bad = 0;
  int cyc   = 0;
  logic [W-1:0] exp_q[$];

  always #2 clk = ~clk;

  redun_cnt_guard #(.CNT_W(W)) dut (
    .clk(clk), .rst_n(rst_n), .start_i(start_i), .step_i(step_i),
    .base_i(base_i), .lim_i(lim_i), .inj_cnt_i(inj_cnt_i),
    .inj_cnt_val_i(inj_cnt_val_i), .inj_st_i(inj_st_i),
    .inj_st_val_i(inj_st_val_i), .flt_set_i(flt_set_i),
    .flt_sel_i(flt_sel_i), .cnt_o(cnt_o), .busy_o(busy_o),
    .done_o(done_o), .locked_o(locked_o), .fault_o(fault_o),
    .intr_fatal_o(intr_fatal_o)
  );

  task automatic check(input bit ok, input string tag, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s act=%0h exp=%0h", tag, act, exp);
    end
  endtask

  task automatic finish_run();
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_bad);
    $finish;
  endtask

  always @(posedge clk) begin
    cyc++;
    if (cyc > 20000) begin
      n_chk++;
      n_bad++;
      $display("FAIL watchdog act=%0d exp=%0d", cyc, 20000);
      finish_run();
    end
  end

  // monitor: pop expected completion value on each done pulse, then check clear
  logic prev_done = 1'b0;
  always @(negedge clk) begin
    if (rst_n) begin
      if (prev_done) check(cnt_o == 0 && !busy_o, "R3 clear after done", cnt_o, 0);
      if (done_o) begin
        if (exp_q.size() == 0) begin
          check(1'b0, "R3 unexpected done", 1, 0);
        end else begin
          logic [W-1:0] e;
          e = exp_q.pop_front();
          check(cnt_o == e, "R3/R4 done count", cnt_o, e);
        end
      end
      prev_done <= done_o;
    end else begin
      prev_done <= 1'b0;
    end
  end

  task automatic do_reset();
    rst_n = 1'b0;
    start_i = 0; step_i = 0; base_i = 0; lim_i = 0;
    inj_cnt_i = 0; inj_cnt_val_i = 0; inj_st_i = 0; inj_st_val_i = 0;
    flt_set_i = 0; flt_sel_i = 0;
    repeat (2) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
  endtask

  // driver: gap = number of idle cycles between steps
  task automatic run_job(input logic [W-1:0] b, input logic [W-1:0] l, input int gap);
    exp_q.push_back(l);
    start_i = 1; base_i = b; lim_i = l;
    @(negedge clk);
    start_i = 0; base_i = ~b; lim_i = ~l;
    check(busy_o && cnt_o == b, "R2 load", cnt_o, b);
    for (int k = 0; k < 2000; k++) begin
      if (!busy_o) break;
      step_i = ((k % (gap + 1)) == 0);
      @(negedge clk);
    end
    step_i = 0;
    repeat (2) @(negedge clk);
  endtask

  initial begin
    do_reset();
    check(cnt_o == 0 && fault_o == 0 && !intr_fatal_o && !locked_o && !busy_o && !done_o,
          "R1 reset", {fault_o, cnt_o}, 0);

    run_job(8'd3, 8'd6, 0);     // R2 R3
    run_job(8'd9, 8'd9, 0);     // R3 base equals limit
    run_job(8'hFE, 8'h01, 0);   // R4 wrap
    run_job(8'd20, 8'd27, 2);   // R2 steps with gaps

    // R2 hold while step low
    exp_q.push_back(8'd12);
    start_i = 1; base_i = 8'd10; lim_i = 8'd12;
    @(negedge clk); start_i = 0;
    repeat (3) @(negedge clk);
    check(cnt_o == 8'd10 && busy_o, "R2 hold", cnt_o, 10);
    step_i = 1;
    repeat (2) @(negedge clk);
    check(cnt_o == 8'd12, "R2 increment", cnt_o, 12);
    step_i = 0;
    repeat (3) @(negedge clk);
    check(exp_q.size() == 0, "R3 all jobs done", exp_q.size(), 0);

    // R6 matching complemented overwrite (idle, true count 0)
    inj_cnt_i = 1; inj_cnt_val_i = 8'hFF;
    @(negedge clk); inj_cnt_i = 0;
    repeat (2) @(negedge clk);
    check(fault_o == 0 && !locked_o, "R6 no fault", fault_o, 0);

    // R5 R7 R8 mismatch
    inj_cnt_i = 1; inj_cnt_val_i = 8'h00;
    @(negedge clk); inj_cnt_i = 0;
    @(negedge clk);
    check(fault_o == 2'b01 && intr_fatal_o, "R5 mismatch bit", fault_o, 1);
    check(!locked_o, "R8 lock not yet", locked_o, 0);
    @(negedge clk);
    check(locked_o, "R8 locked", locked_o, 1);
    start_i = 1; base_i = 8'h55; step_i = 1;
    repeat (3) @(negedge clk);
    start_i = 0; step_i = 0;
    check(!busy_o && cnt_o == 0 && locked_o, "R8 start ignored", cnt_o, 0);
    repeat (5) @(negedge clk);
    check(fault_o == 2'b01 && intr_fatal_o && locked_o, "R7 sticky", fault_o, 1);

    // R9 illegal state code
    do_reset();
    check(fault_o == 0 && !locked_o, "R1 reset clears", fault_o, 0);
    inj_st_i = 1; inj_st_val_i = 6'b111111;
    @(negedge clk); inj_st_i = 0;
    check(!locked_o && !busy_o && !done_o, "R9 illegal seen", locked_o, 0);
    @(negedge clk);
    check(fault_o == 2'b10 && locked_o && intr_fatal_o, "R9 trapped", fault_o, 2);

    // R10 test write mid-job
    do_reset();
    start_i = 1; base_i = 8'd0; lim_i = 8'd50;
    @(negedge clk); start_i = 0; step_i = 1;
    flt_set_i = 1; flt_sel_i = 1'b1;
    @(negedge clk); flt_set_i = 0;
    check(fault_o == 2'b10 && intr_fatal_o && !locked_o, "R10 bit set", fault_o, 2);
    @(negedge clk);
    check(locked_o && !busy_o, "R10 escalates", locked_o, 1);
    begin
      logic [W-1:0] frozen;
      frozen = cnt_o;
      repeat (4) @(negedge clk);
      check(cnt_o == frozen, "R8 count frozen", cnt_o, frozen);
    end
    step_i = 0;

    finish_run();
  end
endmodule